// File: doc/BRIEF.md
# Masked Multi-Lane Vector Adder

This block adds whole vectors of integer elements held in a small vector register file. Each register holds up to `MVL` elements (64 by default). The elements are striped over `LANES` independent lanes: element `i` lives in lane `i mod LANES`, at row `i / LANES` of that lane's slice of the register file. Each lane has its own storage slice and its own adder. No lane reads data from another lane.

A command names a destination register and two sources. The second source is either a vector register or a scalar that is broadcast to every element. The operation covers only the first `VL` elements, where `VL` is the length register. It can be restricted further by a per-element mask. The unit retires one element group per cycle, one element in each lane, and ends the operation with a one-cycle `done` pulse. A side port writes single elements and reads single elements combinationally, so that the register file can be loaded and inspected.

Top module: `vec_lane_alu`

## Requirements
- R1: In vector-vector form (`op_scalar`=0), each processed element `e` of `dst_reg` becomes `srca[e] + srcb[e]` modulo 2^`ELEM_W`.
- R2: In vector-scalar form (`op_scalar`=1), each processed element becomes `srca[e] + scalar_in` modulo 2^`ELEM_W`. The same scalar is used for every element.
- R3: Only elements `0..VL-1` are processed, and elements at or above `VL` keep their old value. A length write larger than `MVL` stores `MVL`.
- R4: With `mask_en`=1, element `e` is written only when bit `e` of the mask register is 1, and elements whose bit is 0 keep their old value. With `mask_en`=0, the mask is ignored.
- R5: A pulse on `mask_clr` sets every mask bit to 1, and `mask_clr` wins over `mask_we` in the same cycle.
- R6: Counting the cycle in which `start` is sampled as cycle 0, `done` is high in cycle `ceil(VL/LANES)+1` and in no other cycle. This timing does not depend on the mask contents or on `mask_en`.
- R7: With `VL`=0, `done` is high in cycle 1 and no register element changes.
- R8: `busy` is high from cycle 1 through the `done` cycle. A `start` while `busy` is high is ignored and does not change the running operation's result or timing.
- R9: After reset, `busy` and `done` are 0, `VL` equals `MVL` and every mask bit is 1.
- R10: While `busy` is high, element writes, length writes and mask writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| elem_we | input | 1 | Single-element write strobe |
| elem_wreg | input | RW | Register written by the element port |
| elem_widx | input | IW | Element index written |
| elem_wdata | input | ELEM_W | Element write data |
| elem_rreg | input | RW | Register read by the element port |
| elem_ridx | input | IW | Element index read |
| elem_rdata | output | ELEM_W | Combinational element read data |
| vl_we | input | 1 | Length register write strobe |
| vl_wdata | input | LEN_IN_W | New length, limited to MVL when stored |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | MVL | New mask; bit e belongs to element e |
| mask_clr | input | 1 | Set all mask bits to 1 |
| start | input | 1 | Begin an operation when idle |
| op_scalar | input | 1 | 1: second operand is scalar_in; 0: srcb_reg |
| mask_en | input | 1 | Apply the mask to element writes |
| dst_reg | input | RW | Destination register |
| srca_reg | input | RW | First source register |
| srcb_reg | input | RW | Second source register (vector form) |
| scalar_in | input | ELEM_W | Broadcast scalar (scalar form) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
If the group counter or the latched length is corrupted, the `done` pulse shifts away from cycle `ceil(VL/LANES)+1`, and the bench sees this in the same operation. A wrong lane-to-element mapping or a wrong mask bit selection shows as a wrong value or an untouched value in a single destination element, at the element read port right after `done`. Every register is read back in full after each operation, so a stray write to a non-destination register or to a tail element is caught before the next command starts. A command latch that reloads while busy shows up as a write to the wrong register or as a stretched operation.

// File: rtl/vla_pkg.sv
package vla_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } vla_state_e;
endpackage

// File: rtl/vla_rst_sync.sv
module vla_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/vla_cfg.sv
module vla_cfg #(
  parameter int MVL      = 64,
  parameter int LEN_IN_W = 8,
  localparam int VLW     = $clog2(MVL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic                vl_we,
  input  logic [LEN_IN_W-1:0] vl_wdata,
  input  logic                mask_we,
  input  logic [MVL-1:0]      mask_wdata,
  input  logic                mask_clr,
  output logic [VLW-1:0]      vl_q,
  output logic [MVL-1:0]      mask_q
);
  localparam logic [LEN_IN_W-1:0] MVL_IN = LEN_IN_W'(MVL);

  logic [VLW-1:0] vl_d;
  logic           vl_en;
  logic [MVL-1:0] mask_d;
  logic           mask_en_w;

  always_comb begin
    vl_en = vl_we && !busy;
    if (vl_wdata > MVL_IN) vl_d = VLW'(MVL);
    else                   vl_d = vl_wdata[VLW-1:0];
  end

  always_comb begin
    mask_en_w = (mask_clr || mask_we) && !busy;
    if (mask_clr) mask_d = '1;
    else          mask_d = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vl_q <= VLW'(MVL);
    else if (vl_en) vl_q <= vl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (mask_en_w) mask_q <= mask_d;
  end

  AST_VL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= VLW'(MVL)); // R3

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clr && !busy) |=> (&mask_q)); // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(vl_q) && $stable(mask_q))); // R10
endmodule

// File: rtl/vla_ctrl.sv
module vla_ctrl import vla_pkg::*; #(
  parameter int MVL   = 64,
  parameter int LANES = 4,
  parameter int RW    = 2,
  parameter int W     = 16,
  localparam int DEPTH = MVL / LANES,
  localparam int VLW   = $clog2(MVL + 1),
  localparam int GIW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_cur,
  input  logic           op_scalar,
  input  logic           mask_en,
  input  logic [RW-1:0]  dst_reg,
  input  logic [RW-1:0]  srca_reg,
  input  logic [RW-1:0]  srcb_reg,
  input  logic [W-1:0]   scalar_in,
  output logic           busy,
  output logic           done,
  output logic           run,
  output logic [GIW-1:0] grp_q,
  output logic [VLW-1:0] vl_eff_q,
  output logic           op_scalar_q,
  output logic           mask_en_q,
  output logic [RW-1:0]  dst_q,
  output logic [RW-1:0]  srca_q,
  output logic [RW-1:0]  srcb_q,
  output logic [W-1:0]   scalar_q
);
  localparam logic [VLW:0] LANE_M1 = (VLW+1)'(LANES - 1);
  localparam logic [VLW:0] LANE_N  = (VLW+1)'(LANES);

  vla_state_e     st_q, st_d;
  logic [GIW-1:0] grp_d;
  logic [VLW-1:0] ngrp_q, ngrp_d;
  logic [VLW:0]   ngrp_wide;
  logic           accept;
  logic           last_grp;

  assign accept    = start && (st_q == ST_IDLE);
  assign ngrp_wide = ({1'b0, vl_cur} + LANE_M1) / LANE_N;
  assign last_grp  = ((VLW'(grp_q) + VLW'(1)) == ngrp_q);

  always_comb begin
    st_d   = st_q;
    grp_d  = grp_q;
    ngrp_d = ngrp_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          grp_d  = '0;
          ngrp_d = ngrp_wide[VLW-1:0];
          st_d   = (vl_cur == '0) ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        grp_d = grp_q + GIW'(1);
        if (last_grp) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      grp_q  <= '0;
      ngrp_q <= '0;
    end else begin
      st_q   <= st_d;
      grp_q  <= grp_d;
      ngrp_q <= ngrp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_eff_q    <= '0;
      op_scalar_q <= 1'b0;
      mask_en_q   <= 1'b0;
      dst_q       <= '0;
      srca_q      <= '0;
      srcb_q      <= '0;
      scalar_q    <= '0;
    end else if (accept) begin
      vl_eff_q    <= vl_cur;
      op_scalar_q <= op_scalar;
      mask_en_q   <= mask_en;
      dst_q       <= dst_reg;
      srca_q      <= srca_reg;
      srcb_q      <= srcb_reg;
      scalar_q    <= scalar_in;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_DONE);
  assign run  = (st_q == ST_RUN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (vl_cur == '0)) |=> done); // R7

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(dst_q) && $stable(srca_q) && $stable(vl_eff_q))); // R8

  AST_GRP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (VLW'(grp_q) < ngrp_q)); // R6
endmodule

// File: rtl/vla_lane.sv
module vla_lane #(
  parameter int W         = 16,
  parameter int NUM_VREGS = 4,
  parameter int MVL       = 64,
  parameter int LANES     = 4,
  parameter int LANE_ID   = 0,
  localparam int DEPTH  = MVL / LANES,
  localparam int RW     = $clog2(NUM_VREGS),
  localparam int GIW    = $clog2(DEPTH),
  localparam int LANE_W = $clog2(LANES),
  localparam int IW     = $clog2(MVL),
  localparam int VLW    = $clog2(MVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [GIW-1:0] grp,
  input  logic [VLW-1:0] vl_eff,
  input  logic [MVL-1:0] mask_vec,
  input  logic           mask_en,
  input  logic           op_scalar,
  input  logic [W-1:0]   scalar,
  input  logic [RW-1:0]  dst,
  input  logic [RW-1:0]  srca,
  input  logic [RW-1:0]  srcb,
  input  logic           ext_we,
  input  logic [RW-1:0]  ext_reg,
  input  logic [GIW-1:0] ext_row,
  input  logic [W-1:0]   ext_data,
  input  logic [RW-1:0]  rd_reg,
  input  logic [GIW-1:0] rd_row,
  output logic [W-1:0]   rd_data
);
  logic [W-1:0]  rf [NUM_VREGS][DEPTH];
  logic [IW-1:0] elem;
  logic          in_range;
  logic          mask_ok;
  logic          op_we;
  logic [W-1:0]  opnd_a;
  logic [W-1:0]  opnd_b;
  logic [W-1:0]  sum;

  assign elem     = {grp, LANE_W'(LANE_ID)};
  assign in_range = (VLW'(elem) < vl_eff);
  assign mask_ok  = !mask_en || mask_vec[elem];
  assign op_we    = run && in_range && mask_ok;

  always_comb begin
    opnd_a = rf[srca][grp];
    if (op_scalar) opnd_b = scalar;
    else           opnd_b = rf[srcb][grp];
    sum = opnd_a + opnd_b;
  end

  always_ff @(posedge clk) begin
    if (op_we)       rf[dst][grp]         <= sum;
    else if (ext_we) rf[ext_reg][ext_row] <= ext_data;
  end

  assign rd_data = rf[rd_reg][rd_row];

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mask_en && !mask_vec[elem]) |=>
      (rf[$past(dst)][$past(grp)] == $past(rf[dst][grp]))); // R4

  AST_TAIL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !in_range) |=>
      (rf[$past(dst)][$past(grp)] == $past(rf[dst][grp]))); // R3

  AST_NO_EXT_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && ext_we)); // R10
endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu #(
  parameter int ELEM_W    = 16,
  parameter int MVL       = 64,
  parameter int LANES     = 4,
  parameter int NUM_VREGS = 4,
  parameter int LEN_IN_W  = 8,
  localparam int RW     = $clog2(NUM_VREGS),
  localparam int IW     = $clog2(MVL),
  localparam int DEPTH  = MVL / LANES,
  localparam int GIW    = $clog2(DEPTH),
  localparam int LANE_W = $clog2(LANES),
  localparam int VLW    = $clog2(MVL + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                elem_we,
  input  logic [RW-1:0]       elem_wreg,
  input  logic [IW-1:0]       elem_widx,
  input  logic [ELEM_W-1:0]   elem_wdata,
  input  logic [RW-1:0]       elem_rreg,
  input  logic [IW-1:0]       elem_ridx,
  output logic [ELEM_W-1:0]   elem_rdata,
  input  logic                vl_we,
  input  logic [LEN_IN_W-1:0] vl_wdata,
  input  logic                mask_we,
  input  logic [MVL-1:0]      mask_wdata,
  input  logic                mask_clr,
  input  logic                start,
  input  logic                op_scalar,
  input  logic                mask_en,
  input  logic [RW-1:0]       dst_reg,
  input  logic [RW-1:0]       srca_reg,
  input  logic [RW-1:0]       srcb_reg,
  input  logic [ELEM_W-1:0]   scalar_in,
  output logic                busy,
  output logic                done
);
  logic              rst_n_s;
  logic [VLW-1:0]    vl_q;
  logic [MVL-1:0]    mask_q;
  logic              run;
  logic [GIW-1:0]    grp_q;
  logic [VLW-1:0]    vl_eff_q;
  logic              op_scalar_q;
  logic              mask_en_q;
  logic [RW-1:0]     dst_q, srca_q, srcb_q;
  logic [ELEM_W-1:0] scalar_q;
  logic [ELEM_W-1:0] lane_rd [LANES];

  vla_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  vla_cfg #(.MVL(MVL), .LEN_IN_W(LEN_IN_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .busy       (busy),
    .vl_we      (vl_we),
    .vl_wdata   (vl_wdata),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .mask_clr   (mask_clr),
    .vl_q       (vl_q),
    .mask_q     (mask_q)
  );

  vla_ctrl #(.MVL(MVL), .LANES(LANES), .RW(RW), .W(ELEM_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (start),
    .vl_cur      (vl_q),
    .op_scalar   (op_scalar),
    .mask_en     (mask_en),
    .dst_reg     (dst_reg),
    .srca_reg    (srca_reg),
    .srcb_reg    (srcb_reg),
    .scalar_in   (scalar_in),
    .busy        (busy),
    .done        (done),
    .run         (run),
    .grp_q       (grp_q),
    .vl_eff_q    (vl_eff_q),
    .op_scalar_q (op_scalar_q),
    .mask_en_q   (mask_en_q),
    .dst_q       (dst_q),
    .srca_q      (srca_q),
    .srcb_q      (srcb_q),
    .scalar_q    (scalar_q)
  );

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic ext_we_ln;
    assign ext_we_ln = elem_we && !busy && (elem_widx[LANE_W-1:0] == LANE_W'(ln));

    vla_lane #(
      .W(ELEM_W), .NUM_VREGS(NUM_VREGS), .MVL(MVL),
      .LANES(LANES), .LANE_ID(ln)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .run       (run),
      .grp       (grp_q),
      .vl_eff    (vl_eff_q),
      .mask_vec  (mask_q),
      .mask_en   (mask_en_q),
      .op_scalar (op_scalar_q),
      .scalar    (scalar_q),
      .dst       (dst_q),
      .srca      (srca_q),
      .srcb      (srcb_q),
      .ext_we    (ext_we_ln),
      .ext_reg   (elem_wreg),
      .ext_row   (elem_widx[IW-1:LANE_W]),
      .ext_data  (elem_wdata),
      .rd_reg    (elem_rreg),
      .rd_row    (elem_ridx[IW-1:LANE_W]),
      .rd_data   (lane_rd[ln])
    );
  end

  assign elem_rdata = lane_rd[elem_ridx[LANE_W-1:0]];

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && !busy) |=> busy); // R8
endmodule

// File: tb/vec_lane_alu_bench.sv
module vec_lane_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int MVL = 64;
  localparam int L   = 4;
  localparam int NR  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          elem_we;
  logic [1:0]    elem_wreg;
  logic [5:0]    elem_widx;
  logic [W-1:0]  elem_wdata;
  logic [1:0]    elem_rreg;
  logic [5:0]    elem_ridx;
  logic [W-1:0]  elem_rdata;
  logic          vl_we;
  logic [7:0]    vl_wdata;
  logic          mask_we;
  logic [MVL-1:0] mask_wdata;
  logic          mask_clr;
  logic          start;
  logic          op_scalar;
  logic          mask_en;
  logic [1:0]    dst_reg, srca_reg, srcb_reg;
  logic [W-1:0]  scalar_in;
  logic          busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int unsigned   mdl [NR][MVL];
  int            vl_m;
  logic [MVL-1:0] mask_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_lane_alu u_vec_lane_alu (
    .clk(clk), .rst_n(rst_n),
    .elem_we(elem_we), .elem_wreg(elem_wreg), .elem_widx(elem_widx),
    .elem_wdata(elem_wdata), .elem_rreg(elem_rreg), .elem_ridx(elem_ridx),
    .elem_rdata(elem_rdata), .vl_we(vl_we), .vl_wdata(vl_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_clr(mask_clr),
    .start(start), .op_scalar(op_scalar), .mask_en(mask_en),
    .dst_reg(dst_reg), .srca_reg(srca_reg), .srcb_reg(srcb_reg),
    .scalar_in(scalar_in), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < NR; r++) begin
      int bad = 0;
      int act_v = 0;
      int exp_v = 0;
      for (int e = 0; e < MVL; e++) begin
        elem_rreg = 2'(r);
        elem_ridx = 6'(e);
        #1;
        if (int'(elem_rdata) != int'(mdl[r][e])) begin
          if (bad == 0) begin
            act_v = int'(elem_rdata);
            exp_v = int'(mdl[r][e]);
          end
          bad++;
        end
      end
      check(bad == 0, req, act_v, exp_v);
    end
  endtask

  task automatic set_vl(input int v);
    vl_we = 1'b1; vl_wdata = 8'(v);
    tick();
    vl_we = 1'b0;
    vl_m = (v > MVL) ? MVL : v;
  endtask

  task automatic set_mask(input logic [MVL-1:0] m);
    mask_we = 1'b1; mask_wdata = m;
    tick();
    mask_we = 1'b0;
    mask_m = m;
  endtask

  // disturb=1: while busy, try a second start, an element write,
  // a length write and a mask write; all must be ignored (R8, R10)
  task automatic run_op(input bit vs, input bit men, input int d, input int a,
                        input int b, input int sc, input bit disturb, input string req);
    int unsigned nv [MVL];
    int n = (vl_m + L - 1) / L;
    int k;
    for (int e = 0; e < MVL; e++) begin
      nv[e] = mdl[d][e];
      if (e < vl_m && (!men || mask_m[e]))
        nv[e] = (mdl[a][e] + (vs ? 32'(sc) : mdl[b][e])) & 32'hFFFF;
    end
    op_scalar = vs; mask_en = men; dst_reg = 2'(d); srca_reg = 2'(a);
    srcb_reg = 2'(b); scalar_in = W'(sc); start = 1'b1;
    tick();
    start = 1'b0;
    k = 1;
    check(busy == 1'b1, "R8 busy in cycle 1", int'(busy), 1);
    while (!done && k < 100) begin
      if (disturb && k == 3) begin
        start = 1'b1; dst_reg = 2'((d + 1) % NR); op_scalar = 1'b1;
        elem_we = 1'b1; elem_wreg = 2'(a); elem_widx = 6'd5; elem_wdata = 16'h1234;
        vl_we = 1'b1; vl_wdata = 8'd4;
        mask_we = 1'b1; mask_wdata = '0;
      end
      tick();
      start = 1'b0; elem_we = 1'b0; vl_we = 1'b0; mask_we = 1'b0;
      k++;
    end
    check(k == n + 1, (vl_m == 0) ? "R7 done cycle" : "R6 done cycle", k, n + 1);
    tick();
    check(done == 1'b0 && busy == 1'b0, "R6 done single pulse", int'(done), 0);
    for (int e = 0; e < MVL; e++) mdl[d][e] = nv[e];
    check_regs(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; elem_we = 0; elem_wreg = 0; elem_widx = 0; elem_wdata = 0;
    elem_rreg = 0; elem_ridx = 0; vl_we = 0; vl_wdata = 0; mask_we = 0;
    mask_wdata = 0; mask_clr = 0; start = 0; op_scalar = 0; mask_en = 0;
    dst_reg = 0; srca_reg = 0; srcb_reg = 0; scalar_in = 0;
    vl_m = MVL; mask_m = '1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    check(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R9 done after reset", int'(done), 0);

    // load with values that overflow when added
    for (int r = 0; r < NR; r++) begin
      for (int e = 0; e < MVL; e++) begin
        mdl[r][e] = (r * 4099 + e * 1021 + 60000) & 32'hFFFF;
        elem_we = 1'b1; elem_wreg = 2'(r); elem_widx = 6'(e);
        elem_wdata = W'(mdl[r][e]);
        tick();
      end
    end
    elem_we = 1'b0;
    check_regs("R10 element load");

    // R9: default length MVL, mask all ones
    run_op(1'b0, 1'b1, 2, 0, 1, 0, 1'b0, "R9 reset length and mask");

    // R1/R2/R3/R7: sweep every length, alternating forms
    for (int v = 0; v <= MVL; v++) begin
      set_vl(v);
      if (v % 2 == 0)
        run_op(1'b0, 1'b0, v % NR, (v + 1) % NR, (v + 2) % NR, 0, 1'b0,
               (v == 0) ? "R7 no write at zero length" : "R1 R3 vector-vector");
      else
        run_op(1'b1, 1'b0, (v + 3) % NR, v % NR, 0, 16'hFF00 + v, 1'b0,
               "R2 R3 vector-scalar");
    end

    // R3: length above MVL is limited
    set_vl(200);
    run_op(1'b1, 1'b0, 1, 2, 0, 7, 1'b0, "R3 length limited to MVL");

    // R4: mask patterns
    set_vl(37);
    set_mask(64'h5555_5555_5555_5555);
    run_op(1'b0, 1'b1, 3, 0, 2, 0, 1'b0, "R4 alternating mask");
    set_mask(64'hF0E1_D2C3_B4A5_9687);
    run_op(1'b1, 1'b1, 0, 3, 0, 16'h8001, 1'b0, "R4 irregular mask");
    set_vl(64);
    set_mask('0);
    run_op(1'b0, 1'b1, 1, 1, 2, 0, 1'b0, "R4 zero mask writes nothing");
    run_op(1'b0, 1'b0, 2, 3, 1, 0, 1'b0, "R4 mask ignored when disabled");

    // R5: clear wins over write
    mask_clr = 1'b1; mask_we = 1'b1; mask_wdata = '0;
    tick();
    mask_clr = 1'b0; mask_we = 1'b0; mask_m = '1;
    run_op(1'b1, 1'b1, 3, 2, 0, 16'h0101, 1'b0, "R5 cleared mask all ones");

    // R8/R10: disturbance while busy
    set_mask(64'hFFFF_0000_FFFF_0000);
    run_op(1'b0, 1'b1, 0, 1, 3, 0, 1'b1, "R8 R10 ignored while busy");
    // length write during busy was ignored: still 64 -> 16 groups
    run_op(1'b1, 1'b0, 2, 0, 0, 3, 1'b0, "R10 length unchanged");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule